// File: doc/BRIEF.md
# Partial-Word Transfer Unit

This unit carries out the four unaligned word transfer operations of a 32-bit load/store pipeline. Two of them fill part of a register from memory, and two of them place part of a register into memory. A left or right variant picks which bytes of the register take part. The byte offset in the low two bits of the effective address sets how many bytes take part. Each operation reads the aligned word that contains the addressed byte.

A load merges the bytes it reads into the current register value. It returns the merged word together with a write-back enable. A store merges register bytes into the word it has read. It then writes that word back to the same aligned address, so a memory without byte enables sees a plain read-modify-write.

The caller presents an operation, an effective byte address, the register value and the destination index, then pulses a start strobe. Memory is reached through a request/acknowledge port. Memory may hold the acknowledge off for any number of cycles. The end of the operation is marked by a one-cycle done pulse.

Top module: `partial_word_xfer`

## Requirements
- R1: After reset, busy_o, done_o, wb_en_o, mem_req_o and mem_we_o are all low.
- R2: Every memory request uses the effective address with its low two bits forced to zero.
- R3: Operation code 2'b00 (left load), with offset o = addr_i[1:0], returns (mem << (24-8o)) | (reg & (32'h00FFFFFF >> 8o)).
- R4: Operation code 2'b01 (right load) returns (mem >> 8o) | (reg & ~(32'hFFFFFFFF >> 8o)).
- R5: Operation code 2'b10 (left store) writes (reg >> (24-8o)) | (mem & ~(32'hFFFFFFFF >> (24-8o))).
- R6: Operation code 2'b11 (right store) writes (reg << 8o) | (mem & ~(32'hFFFFFFFF << 8o)).
- R7: Start in idle moves the unit to a read request in the next cycle.
  - A load makes one read and raises done in the cycle after the read acknowledge.
  - A store follows the read acknowledge with a write to the same address (mem_we_o high) and raises done in the cycle after the write acknowledge.
- R8: done_o is high for exactly one cycle per operation. result_o carries the merged word (load result or written word) while done_o is high.
- R9: wb_en_o is high only together with done_o, for loads whose destination index is nonzero. A load to index 0 still performs its memory read.
- R10: A start strobe while busy_o is high is ignored: it neither alters the operation in flight nor starts another one.
- R11: While a request is not acknowledged, mem_req_o, mem_we_o and mem_addr_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | Operation code (see R3-R6) |
| addr_i | input | AW | Effective byte address |
| reg_val_i | input | 32 | Current register value |
| dst_idx_i | input | 5 | Destination register index for loads |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Merged word, valid with done_o |
| wb_en_o | output | 1 | Register write-back enable |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Aligned word address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The bench runs every operation at all four offsets, with zero-wait and multi-cycle acknowledges. At offsets 0 and 3 a swapped mask or shift shows up as a whole wrong byte set, so a design that mixed up the left and right tables would return or store shifted bytes. Stores are checked against the memory contents afterwards. That catches a design that wrote without reading first or wrote to an unaligned address.

A start pulsed in the middle of a transfer must leave the transfer and memory untouched. A unit that latched new operands while busy would corrupt the result. A load to index 0 must still read memory yet hold the write-back enable low.

// File: rtl/swx_pkg.sv
package swx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned OFS_W   = $clog2(LANES);
  localparam int unsigned SH_W    = $clog2(WORD_W);
  localparam int unsigned RIDX_W  = 5;

  typedef enum logic [1:0] {
    XF_LD_LEFT  = 2'b00,
    XF_LD_RIGHT = 2'b01,
    XF_ST_LEFT  = 2'b10,
    XF_ST_RIGHT = 2'b11
  } xfer_op_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2,
    SEQ_FIN  = 2'd3
  } seq_state_e;

  typedef struct packed {
    xfer_op_e              op;
    logic [OFS_W-1:0]      ofs;
    logic [WORD_W-1:0]     rval;
    logic [RIDX_W-1:0]     dst;
  } xfer_cmd_t;

  function automatic logic op_is_store(xfer_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/swx_capture.sv
module swx_capture
  import swx_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  xfer_op_e             op_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [WORD_W-1:0]    rval_i,
  input  logic [RIDX_W-1:0]    dst_i,
  output xfer_cmd_t            cmd_o,
  output logic [AW-1:0]        waddr_o
);
  xfer_cmd_t         cmd_q;
  logic [AW-OFS_W-1:0] wa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      wa_q  <= '0;
    end else if (load_i) begin
      cmd_q.op   <= op_i;
      cmd_q.ofs  <= addr_i[OFS_W-1:0];
      cmd_q.rval <= rval_i;
      cmd_q.dst  <= dst_i;
      wa_q       <= addr_i[AW-1:OFS_W];
    end
  end

  assign cmd_o   = cmd_q;
  assign waddr_o = {wa_q, {OFS_W{1'b0}}};
endmodule

// File: rtl/swx_merge.sv
module swx_merge
  import swx_pkg::*;
(
  input  xfer_op_e          op_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_W-1:0] rval_i,
  input  logic [WORD_W-1:0] mval_i,
  output logic [WORD_W-1:0] merged_o
);
  localparam logic [SH_W-1:0] TOP_SH = SH_W'(WORD_W - 8);
  localparam logic [WORD_W-1:0] ONES = '1;

  logic [SH_W-1:0] sh, sh_inv;
  logic [WORD_W-1:0] keep_mask, data_part;

  assign sh     = SH_W'({ofs_i, 3'b000});
  assign sh_inv = TOP_SH - sh;

  always_comb begin
    unique case (op_i)
      XF_LD_LEFT: begin
        data_part = mval_i << sh_inv;
        keep_mask = (ONES >> 8) >> sh;
      end
      XF_LD_RIGHT: begin
        data_part = mval_i >> sh;
        keep_mask = ~(ONES >> sh);
      end
      XF_ST_LEFT: begin
        data_part = rval_i >> sh_inv;
        keep_mask = ~(ONES >> sh_inv);
      end
      default: begin
        data_part = rval_i << sh;
        keep_mask = ~(ONES << sh);
      end
    endcase
  end

  // loads keep register bytes, stores keep memory bytes
  assign merged_o = data_part |
                    ((op_is_store(op_i) ? mval_i : rval_i) & keep_mask);
endmodule

// File: rtl/swx_ctrl.sv
module swx_ctrl
  import swx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       is_store_i,
  input  logic       ack_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       rd_take_o
);
  seq_state_e st_q, st_d;

  assign accept_o  = (st_q == SEQ_IDLE) && start_i;
  assign rd_take_o = (st_q == SEQ_RD) && ack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (start_i) st_d = SEQ_RD;
      SEQ_RD:   if (ack_i)   st_d = is_store_i ? SEQ_WR : SEQ_FIN;
      SEQ_WR:   if (ack_i)   st_d = SEQ_FIN;
      default:               st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/partial_word_xfer.sv
module partial_word_xfer
  import swx_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       reg_val_i,
  input  logic [4:0]        dst_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       result_o,
  output logic              wb_en_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  seq_state_e        state;
  logic              accept, rd_take;
  xfer_cmd_t         cmd;
  logic [AW-1:0]     waddr;
  logic [WORD_W-1:0] merged, data_q;

  swx_capture #(.AW(AW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .op_i    (xfer_op_e'(op_i)),
    .addr_i  (addr_i),
    .rval_i  (reg_val_i),
    .dst_i   (dst_idx_i),
    .cmd_o   (cmd),
    .waddr_o (waddr)
  );

  swx_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .is_store_i (op_is_store(cmd.op)),
    .ack_i      (mem_ack_i),
    .state_o    (state),
    .accept_o   (accept),
    .rd_take_o  (rd_take)
  );

  swx_merge u_merge (
    .op_i     (cmd.op),
    .ofs_i    (cmd.ofs),
    .rval_i   (cmd.rval),
    .mval_i   (mem_rdata_i),
    .merged_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_take) data_q <= merged;
  end

  assign busy_o      = (state != SEQ_IDLE);
  assign done_o      = (state == SEQ_FIN);
  assign wb_en_o     = done_o && !op_is_store(cmd.op) && (cmd.dst != '0);
  assign mem_req_o   = (state == SEQ_RD) || (state == SEQ_WR);
  assign mem_we_o    = (state == SEQ_WR);
  assign mem_addr_o  = waddr;
  assign mem_wdata_o = data_q;
  assign result_o    = data_q;
endmodule

// File: rtl/partial_word_xfer_chk.sv
module partial_word_xfer_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          wb_en_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R2

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_WB_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o); // R9

  AST_WE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o); // R7

  AST_WRITE_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mem_req_o) && mem_addr_o == $past(mem_addr_o)); // R7

  AST_START_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> mem_req_o && !mem_we_o); // R7

  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_ack_i) && $past(mem_req_o)); // R7
endmodule

bind partial_word_xfer partial_word_xfer_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .wb_en_o    (wb_en_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o)
);

// File: tb/partial_word_xfer_test.sv
module partial_word_xfer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 0, rst_ni = 0, start_i = 0;
  logic [1:0]  op_i = 0;
  logic [31:0] addr_i = 0, reg_val_i = 0, mem_rdata_i = 0;
  logic [4:0]  dst_idx_i = 0;
  logic        mem_ack_i = 0;
  logic        busy_o, done_o, wb_en_o, mem_req_o, mem_we_o;
  logic [31:0] result_o, mem_addr_o, mem_wdata_o;

  partial_word_xfer #(.AW(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .addr_i(addr_i), .reg_val_i(reg_val_i), .dst_idx_i(dst_idx_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .wb_en_o(wb_en_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, lat_cur = 0, wcnt = 0, rd_cnt = 0;
  bit finished = 0;
  logic [31:0] mem_q [16];

  // reference model state: 0 idle, 1 read, 2 write, 3 done
  int          mst = 0;
  logic [1:0]  m_op;
  logic [31:0] m_addr, m_reg, m_data;
  logic [4:0]  m_dst;
  string       op_req [4] = '{"R3", "R4", "R5", "R6"};

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_merge(logic [1:0] op, int o, logic [31:0] r, logic [31:0] m);
    logic [31:0] res;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      case (op)
        2'b00: b = (k >= 3 - o) ? m[8*(k+o-3) +: 8] : r[8*k +: 8];
        2'b01: b = (k <= 3 - o) ? m[8*(k+o) +: 8]   : r[8*k +: 8];
        2'b10: b = (k <= o)     ? r[8*(k+3-o) +: 8] : m[8*k +: 8];
        default: b = (k >= o)   ? r[8*(k-o) +: 8]   : m[8*k +: 8];
      endcase
      res[8*k +: 8] = b;
    end
    return res;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      summary();
    end
    if (!rst_ni) begin
      mst = 0;
    end else begin
      // advance model with inputs seen at the last rising edge
      case (mst)
        0: if (start_i) begin
             m_op = op_i; m_addr = addr_i; m_reg = reg_val_i; m_dst = dst_idx_i; mst = 1;
           end
        1: if (mem_ack_i) begin
             m_data = ref_merge(m_op, int'(m_addr[1:0]), m_reg, mem_rdata_i);
             mst = m_op[1] ? 2 : 3;
           end
        2: if (mem_ack_i) mst = 3;
        default: mst = 0;
      endcase
      chk(busy_o == (mst != 0), "R10", "busy", 32'(busy_o), 32'(mst != 0));
      chk(done_o == (mst == 3), "R8", "done", 32'(done_o), 32'(mst == 3));
      chk(mem_req_o == (mst == 1 || mst == 2), "R7", "req", 32'(mem_req_o), 32'(mst == 1 || mst == 2));
      chk(mem_we_o == (mst == 2), "R7", "we", 32'(mem_we_o), 32'(mst == 2));
      chk(wb_en_o == (mst == 3 && !m_op[1] && m_dst != 0), "R9", "wb_en",
          32'(wb_en_o), 32'(mst == 3 && !m_op[1] && m_dst != 0));
      if (mst == 1 || mst == 2)
        chk(mem_addr_o == {m_addr[31:2], 2'b00}, "R2", "addr", mem_addr_o, {m_addr[31:2], 2'b00});
      if (mst == 2)
        chk(mem_wdata_o == m_data, op_req[m_op], "wdata", mem_wdata_o, m_data);
      if (mst == 3)
        chk(result_o == m_data, op_req[m_op], "result", result_o, m_data);
    end
    // memory responder, acknowledge after lat_cur wait cycles
    if (mem_ack_i) mem_ack_i = 0;
    else if (rst_ni && mem_req_o) begin
      if (wcnt >= lat_cur) begin
        wcnt = 0;
        mem_ack_i = 1;
        if (mem_we_o) mem_q[mem_addr_o[5:2]] = mem_wdata_o;
        else begin
          mem_rdata_i = mem_q[mem_addr_o[5:2]];
          rd_cnt++;
        end
      end else wcnt++;
    end
  end

  task automatic run_xfer(logic [1:0] op, logic [31:0] addr, logic [31:0] rv, logic [4:0] dst, int lat);
    logic [31:0] pre, exp;
    int rd0;
    pre = mem_q[addr[5:2]];
    rd0 = rd_cnt;
    lat_cur = lat;
    @(negedge clk); #1;
    op_i = op; addr_i = addr; reg_val_i = rv; dst_idx_i = dst; start_i = 1;
    @(negedge clk); #1;
    start_i = 0;
    while (!done_o) begin @(negedge clk); #1; end
    exp = ref_merge(op, int'(addr[1:0]), rv, pre);
    chk(result_o == exp, op_req[op], "done word", result_o, exp);
    chk(rd_cnt == rd0 + 1, "R7", "one read", 32'(rd_cnt), 32'(rd0 + 1));
    if (op[1]) chk(mem_q[addr[5:2]] == exp, op_req[op], "stored word", mem_q[addr[5:2]], exp);
    else       chk(mem_q[addr[5:2]] == pre, "R7", "load leaves memory", mem_q[addr[5:2]], pre);
    @(negedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_q[i] = 32'h1A2B3C4D + 32'(i) * 32'h01010101;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !done_o && !wb_en_o && !mem_req_o && !mem_we_o, "R1", "reset outputs",
        {27'd0, busy_o, done_o, wb_en_o, mem_req_o, mem_we_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk); #1;
    chk(!busy_o && !mem_req_o, "R1", "idle after reset", {30'd0, busy_o, mem_req_o}, 32'd0);

    // R3..R6 every op at every offset, varied latency (R11)
    for (int op = 0; op < 4; op++)
      for (int o = 0; o < 4; o++)
        run_xfer(2'(op), 32'h0000_0010 + 32'(4*op) + 32'(o), 32'hA1B2C3D4 ^ 32'(op*o*16'h1357),
                 5'(3 + op), (op + o) % 3);

    // R11 long acknowledge delay
    run_xfer(2'b10, 32'h0000_0031, 32'hCAFEF00D, 5'd9, 6);
    run_xfer(2'b00, 32'h0000_0032, 32'h0BADBEEF, 5'd9, 5);

    // R9 load to index 0: read still happens, no write-back
    run_xfer(2'b01, 32'h0000_0026, 32'h55AA55AA, 5'd0, 1);
    run_xfer(2'b00, 32'h0000_0024, 32'h12345678, 5'd0, 0);

    // R10 start while busy: second request must be dropped
    begin
      logic [31:0] other;
      int rd0;
      other = mem_q[4'd14];
      rd0 = rd_cnt;
      lat_cur = 4;
      @(negedge clk); #1;
      op_i = 2'b01; addr_i = 32'h0000_0029; reg_val_i = 32'hFEEDFACE; dst_idx_i = 5'd7; start_i = 1;
      @(negedge clk); #1; start_i = 0;
      @(negedge clk); #1;
      op_i = 2'b11; addr_i = 32'h0000_0038; reg_val_i = 32'h99999999; start_i = 1;
      @(negedge clk); #1; start_i = 0;
      while (!done_o) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      repeat (3) begin
        chk(!busy_o && !mem_req_o, "R10", "no second transfer", {30'd0, busy_o, mem_req_o}, 32'd0);
        @(negedge clk); #1;
      end
      chk(mem_q[4'd14] == other, "R10", "ignored store target", mem_q[4'd14], other);
      chk(rd_cnt == rd0 + 1, "R10", "read count", 32'(rd_cnt), 32'(rd0 + 1));
    end

    // back-to-back store then load of same word
    run_xfer(2'b11, 32'h0000_0003, 32'h00C0FFEE, 5'd1, 0);
    run_xfer(2'b00, 32'h0000_0001, 32'h77777777, 5'd31, 0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule